// File: doc/BRIEF.md
# Host Command Frame Receiver

This block sits behind the byte receiver of a host serial link and turns the incoming byte stream into command messages. A message starts with a marker byte (0x60 for an ordinary frame, 0xE0 for a negative frame carrying a status). Two length bytes follow, most significant first, then a command code, then as many payload bytes as the length names, then one check byte. The receiver hunts for a marker and walks the header. It stores the payload and confirms that the XOR of all bytes, the check byte included, comes to zero.

A good frame goes to a consumer as a stream of beats on a valid/ready handshake. The command code comes first, flagged as the head, and the payload bytes follow in arrival order, with the final beat flagged as last. Faults are reported as one-cycle error events with a two-bit code. The faults are an oversized length, a bad check byte, silence between the characters of a frame, and a frame that arrives while the previous one is still waiting to be taken. Silence is measured by a clock-tick count that is a parameter, so that a 10 ms limit in the chip becomes a few cycles in simulation.

Top module: `hostFrameRx`

## Requirements
- R1: While hunting, every byte other than 0x60 and 0xE0 is dropped with no beat and no error event.
- R2: A good frame yields length+1 beats: the first carries the command code with outHead=1, and the payload bytes follow in order. outLast=1 marks only the final beat. outNeg is 1 for a frame opened by 0xE0 and 0 for one opened by 0x60.
- R3: A frame with length 0 yields exactly one beat, with both outHead and outLast set to 1.
- R4: If the XOR of all frame bytes, the check byte included, is not zero, the frame gives no beats and raises error code 1.
- R5: A length field (byte 2 high, byte 3 low) above MAX_LEN raises error code 0 on its low byte. The receiver then hunts for a new marker.
- R6: Inside a frame, GAP_TICKS idle cycles between two bytes are accepted. GAP_TICKS+1 idle cycles raise error code 2 and send the receiver back to hunting. No silence while hunting raises an error.
- R7: A frame whose marker arrives while a delivery is still pending gives no beats and raises error code 3 after its check byte. The pending frame is then delivered unchanged.
- R8: While outValid=1 and outReady=0, outValid, outData, outHead and outLast hold their values.
- R9: errValid is a single-cycle pulse in the cycle after the byte, or the idle cycle, that caused it.
- R10: After reset, outValid and errValid are 0 and the receiver is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxValid | input | 1 | A received byte is present this cycle |
| rxByte | input | 8 | Received byte |
| outValid | output | 1 | A beat is offered to the consumer |
| outReady | input | 1 | Consumer takes the beat |
| outHead | output | 1 | Beat is the command code |
| outLast | output | 1 | Beat is the final one of the frame |
| outNeg | output | 1 | Frame was opened by the negative marker |
| outData | output | 8 | Beat data |
| errValid | output | 1 | Error event pulse |
| errCode | output | 2 | 0 length, 1 check, 2 silence, 3 frame lost |

## Verification
The bench builds the block with MAX_LEN=8 and GAP_TICKS=6. With these values it can send every legal payload length with both markers and lengths just above the limit. It can also place a gap of exactly the limit and of one cycle more. The small buffer lets a full frame arrive behind a stalled delivery within a few dozen cycles, so the frame-lost path and the stalled handshake are covered together. The bench works out every beat and every error timing from the frame bytes alone.

// File: rtl/hfr_pkg.sv
package hfr_pkg;

  localparam logic [7:0] MARK_ACK = 8'h60;
  localparam logic [7:0] MARK_NAK = 8'hE0;

  typedef enum logic [1:0] {
    ERR_LEN  = 2'd0,
    ERR_LRC  = 2'd1,
    ERR_GAP  = 2'd2,
    ERR_LOST = 2'd3
  } errKind_t;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_LENHI,
    ST_LENLO,
    ST_CMD,
    ST_PAY,
    ST_CHK
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startFrame;
    logic setLenHi;
    logic setLenLo;
    logic setCmd;
    logic accXor;
    logic countPay;
    logic writePay;
    logic launch;
    logic popBeat;
  } ctl_t;

endpackage

// File: rtl/hfrDatapath.sv
module hfrDatapath
  import hfr_pkg::*;
#(
  parameter int MAX_LEN = 506
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctl_t       ctl,
  input  logic [7:0] rxByte,
  output logic       lenOver,
  output logic       lenZero,
  output logic       payLast,
  output logic       xorOk,
  output logic       lastBeat,
  output logic       outHead,
  output logic       outNeg,
  output logic [7:0] outData
);

  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int IDX_W = $clog2(MAX_LEN);
  localparam logic [15:0]      MAX16 = 16'(MAX_LEN);
  localparam logic [LEN_W-1:0] ONE   = LEN_W'(1);

  logic [7:0]       lenHi;
  logic [LEN_W-1:0] rxLen;
  logic [LEN_W-1:0] payCnt;
  logic [7:0]       xorAcc;
  logic [7:0]       cmdRx;
  logic             negRx;

  logic [LEN_W-1:0] dLen;
  logic [7:0]       dCmd;
  logic             dNeg;
  logic [LEN_W-1:0] rdIdx;

  logic [7:0]       payMem [MAX_LEN];
  logic [IDX_W-1:0] rdAddr;

  // receive side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenHi  <= '0;
      rxLen  <= '0;
      payCnt <= '0;
      xorAcc <= '0;
      cmdRx  <= '0;
      negRx  <= 1'b0;
    end else begin
      if (ctl.startFrame) begin
        xorAcc <= rxByte;
        negRx  <= rxByte[7];
        payCnt <= '0;
      end else if (ctl.accXor) begin
        xorAcc <= xorAcc ^ rxByte;
      end
      if (ctl.setLenHi) lenHi <= rxByte;
      if (ctl.setLenLo) rxLen <= LEN_W'({lenHi, rxByte});
      if (ctl.setCmd)   cmdRx <= rxByte;
      if (ctl.countPay) payCnt <= payCnt + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.writePay) payMem[payCnt[IDX_W-1:0]] <= rxByte;
  end

  // delivery side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dLen  <= '0;
      dCmd  <= '0;
      dNeg  <= 1'b0;
      rdIdx <= '0;
    end else if (ctl.launch) begin
      dLen  <= rxLen;
      dCmd  <= cmdRx;
      dNeg  <= negRx;
      rdIdx <= '0;
    end else if (ctl.popBeat) begin
      rdIdx <= rdIdx + ONE;
    end
  end

  always_comb begin
    lenOver  = {lenHi, rxByte} > MAX16;
    lenZero  = (rxLen == '0);
    payLast  = (payCnt == rxLen - ONE);
    xorOk    = ((xorAcc ^ rxByte) == 8'h00);
    lastBeat = (rdIdx == dLen);
    rdAddr   = IDX_W'(rdIdx - ONE);
    outHead  = (rdIdx == '0);
    outNeg   = dNeg;
    outData  = outHead ? dCmd : payMem[rdAddr];
  end

endmodule

// File: rtl/hfrControl.sv
module hfrControl
  import hfr_pkg::*;
#(
  parameter int GAP_TICKS = 2500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       lenOver,
  input  logic       lenZero,
  input  logic       payLast,
  input  logic       xorOk,
  input  logic       lastBeat,
  input  logic       outReady,
  output ctl_t       ctl,
  output logic       outValid,
  output logic       errValid,
  output logic [1:0] errCode
);

  localparam int GAP_W = $clog2(GAP_TICKS + 1);
  localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(GAP_TICKS);

  rxState_t         state, nxt;
  logic [GAP_W-1:0] gapCnt;
  logic             blocked;
  logic             busy;
  logic             errFire;
  errKind_t         errKind;

  always_comb begin
    ctl         = '0;
    nxt         = state;
    errFire     = 1'b0;
    errKind     = ERR_LEN;
    ctl.popBeat = busy && outReady;
    unique case (state)
      ST_HUNT: if (rxValid && (rxByte == MARK_ACK || rxByte == MARK_NAK)) begin
        ctl.startFrame = 1'b1;
        nxt            = ST_LENHI;
      end
      ST_LENHI: if (rxValid) begin
        ctl.setLenHi = 1'b1;
        ctl.accXor   = 1'b1;
        nxt          = ST_LENLO;
      end
      ST_LENLO: if (rxValid) begin
        if (lenOver) begin
          errFire = 1'b1;
          errKind = ERR_LEN;
          nxt     = ST_HUNT;
        end else begin
          ctl.setLenLo = 1'b1;
          ctl.accXor   = 1'b1;
          nxt          = ST_CMD;
        end
      end
      ST_CMD: if (rxValid) begin
        ctl.setCmd = 1'b1;
        ctl.accXor = 1'b1;
        nxt        = lenZero ? ST_CHK : ST_PAY;
      end
      ST_PAY: if (rxValid) begin
        ctl.countPay = 1'b1;
        ctl.writePay = !blocked;
        ctl.accXor   = 1'b1;
        if (payLast) nxt = ST_CHK;
      end
      ST_CHK: if (rxValid) begin
        nxt = ST_HUNT;
        if (blocked) begin
          errFire = 1'b1;
          errKind = ERR_LOST;
        end else if (!xorOk) begin
          errFire = 1'b1;
          errKind = ERR_LRC;
        end else begin
          ctl.launch = 1'b1;
        end
      end
      default: nxt = ST_HUNT;
    endcase
    // silence inside a frame
    if (state != ST_HUNT && !rxValid && gapCnt == GAP_LIM) begin
      nxt     = ST_HUNT;
      errFire = 1'b1;
      errKind = ERR_GAP;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      gapCnt   <= '0;
      blocked  <= 1'b0;
      busy     <= 1'b0;
      errValid <= 1'b0;
      errCode  <= '0;
    end else begin
      state <= nxt;
      if (state == ST_HUNT || rxValid) gapCnt <= '0;
      else if (gapCnt != GAP_LIM)      gapCnt <= gapCnt + GAP_W'(1);
      if (ctl.startFrame) blocked <= busy;
      if (ctl.launch)                      busy <= 1'b1;
      else if (ctl.popBeat && lastBeat)    busy <= 1'b0;
      errValid <= errFire;
      errCode  <= errKind;
    end
  end

  assign outValid = busy;

endmodule

// File: rtl/hostFrameRx.sv
module hostFrameRx
  import hfr_pkg::*;
#(
  parameter int MAX_LEN   = 506,
  parameter int GAP_TICKS = 2500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  output logic       outValid,
  input  logic       outReady,
  output logic       outHead,
  output logic       outLast,
  output logic       outNeg,
  output logic [7:0] outData,
  output logic       errValid,
  output logic [1:0] errCode
);

  ctl_t ctl;
  logic lenOver, lenZero, payLast, xorOk, lastBeat;

  hfrControl #(.GAP_TICKS(GAP_TICKS)) i_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
    .lenOver(lenOver), .lenZero(lenZero), .payLast(payLast), .xorOk(xorOk),
    .lastBeat(lastBeat), .outReady(outReady), .ctl(ctl), .outValid(outValid),
    .errValid(errValid), .errCode(errCode)
  );

  hfrDatapath #(.MAX_LEN(MAX_LEN)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxByte(rxByte),
    .lenOver(lenOver), .lenZero(lenZero), .payLast(payLast), .xorOk(xorOk),
    .lastBeat(lastBeat), .outHead(outHead), .outNeg(outNeg), .outData(outData)
  );

  assign outLast = lastBeat;

endmodule

// File: rtl/hfrChecker.sv
module hfrChecker (
  input logic       clk,
  input logic       rstN,
  input logic       rxValid,
  input logic       outValid,
  input logic       outReady,
  input logic       outHead,
  input logic       outLast,
  input logic [7:0] outData,
  input logic       errValid,
  input logic [1:0] errCode
);

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outHead) && $stable(outLast)); // R8

  AST_HEAD_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> outHead); // R2

  AST_GAP_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !(errValid && errCode == 2'd2)); // R6

  AST_LEN_ON_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    errValid && errCode == 2'd0 |-> $past(rxValid)); // R5

  AST_CHECK_ON_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    errValid && errCode == 2'd1 |-> $past(rxValid)); // R9

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outLast |=> !outValid); // R2

endmodule

bind hostFrameRx hfrChecker i_chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .outValid(outValid),
  .outReady(outReady), .outHead(outHead), .outLast(outLast),
  .outData(outData), .errValid(errValid), .errCode(errCode)
);

// File: tb/test_hostFrameRx.sv
module test_hostFrameRx;

  localparam int ML = 8;
  localparam int GT = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       outReady = 1'b0;
  logic       outValid, outHead, outLast, outNeg, errValid;
  logic [7:0] outData;
  logic [1:0] errCode;

  bit readyMode = 1'b0;
  bit readyHold = 1'b1;
  bit tog = 1'b0;

  int nChecks = 0;
  int nErrors = 0;

  int         beatTotal = 0;
  int         errTotal = 0;
  logic [7:0] bData [64];
  bit         bHead [64];
  bit         bLast [64];
  bit         bNeg  [64];
  logic [1:0] lastErr = 2'd0;
  logic [7:0] pay [16];

  hostFrameRx #(.MAX_LEN(ML), .GAP_TICKS(GT)) i_hostFrameRx (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
    .outValid(outValid), .outReady(outReady), .outHead(outHead),
    .outLast(outLast), .outNeg(outNeg), .outData(outData),
    .errValid(errValid), .errCode(errCode)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    #1;
    tog = ~tog;
    outReady = readyMode ? tog : readyHold;
  end

  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      bData[beatTotal % 64] = outData;
      bHead[beatTotal % 64] = outHead;
      bLast[beatTotal % 64] = outLast;
      bNeg[beatTotal % 64]  = outNeg;
      beatTotal++;
    end
    if (rstN && errValid) begin
      errTotal++;
      lastErr = errCode;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called just after a rising edge; returns just after the acceptance edge plus idle cycles
  task automatic sendByte(input logic [7:0] b, input int idle);
    rxValid = 1'b1;
    rxByte  = b;
    @(posedge clk); #1;
    rxValid = 1'b0;
    for (int k = 0; k < idle; k++) begin
      @(posedge clk); #1;
    end
  endtask

  // all bytes except the check byte; returns the xor of them
  task automatic sendBody(input logic [7:0] mark, input logic [15:0] len,
                          input logic [7:0] cmd, input int idle, output logic [7:0] acc);
    acc = mark ^ len[15:8] ^ len[7:0] ^ cmd;
    sendByte(mark, idle);
    sendByte(len[15:8], idle);
    sendByte(len[7:0], idle);
    sendByte(cmd, idle);
    for (int i = 0; i < int'(len); i++) begin
      acc = acc ^ pay[i];
      sendByte(pay[i], idle);
    end
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic expectFrame(input int base, input logic [7:0] mark, input int len,
                             input logic [7:0] cmd, input string req);
    check(beatTotal - base == len + 1, req, beatTotal - base, len + 1);
    for (int i = 0; i <= len && i < beatTotal - base; i++) begin
      int ix;
      ix = (base + i) % 64;
      check(bData[ix] == ((i == 0) ? cmd : pay[i-1]), req, bData[ix], (i == 0) ? cmd : pay[i-1]);
      check(bHead[ix] == (i == 0), req, bHead[ix], i == 0);
      check(bLast[ix] == (i == len), req, bLast[ix], i == len);
      check(bNeg[ix] == mark[7], req, bNeg[ix], mark[7]);
    end
  endtask

  initial begin
    fork
      begin : mainSeq
        logic [7:0] acc;
        int base, ebase;

        settle(3);
        rstN = 1'b1;
        settle(1);
        // R10 reset state
        check(outValid == 1'b0, "R10", outValid, 0);
        check(errValid == 1'b0, "R10", errValid, 0);

        // R2 R3 R8 R6: sweep lengths, markers, gaps and ready patterns
        for (int L = 0; L <= ML; L++) begin
          for (int m = 0; m < 2; m++) begin
            logic [7:0] mk, cmd;
            int idle;
            mk   = m ? 8'hE0 : 8'h60;
            cmd  = 8'(8'h20 + L * 3 + m);
            idle = (L % 3 == 2) ? GT : (L % 3);
            readyMode = (L % 2) != m;
            readyHold = 1'b1;
            for (int i = 0; i < L; i++) pay[i] = 8'((L * 7 + i * 13) ^ 8'h5A);
            base  = beatTotal;
            ebase = errTotal;
            sendBody(mk, 16'(L), cmd, idle, acc);
            sendByte(acc, 0);
            settle(3 * ML + 8);
            if (L == 0) expectFrame(base, mk, L, cmd, "R3");
            else expectFrame(base, mk, L, cmd, "R2");
            check(errTotal == ebase, (idle == GT) ? "R6" : "R8", errTotal - ebase, 0);
          end
        end
        readyMode = 1'b0;
        readyHold = 1'b1;
        settle(2);

        // R1: noise while hunting
        base = beatTotal; ebase = errTotal;
        sendByte(8'h00, 1); sendByte(8'h61, 0); sendByte(8'hFF, 2); sendByte(8'h5A, 0);
        settle(10);
        check(beatTotal == base, "R1", beatTotal - base, 0);
        check(errTotal == ebase, "R1", errTotal - ebase, 0);
        pay[0] = 8'h11; pay[1] = 8'h22;
        sendByte(8'h13, 0);
        sendBody(8'h60, 16'd2, 8'h77, 0, acc);
        sendByte(acc, 0);
        settle(10);
        expectFrame(base, 8'h60, 2, 8'h77, "R1");

        // R5: length one above limit, error on the low length byte
        base = beatTotal; ebase = errTotal;
        sendByte(8'h60, 0); sendByte(8'h00, 0); sendByte(8'(ML + 1), 0);
        @(negedge clk);
        check(errValid == 1'b1, "R5", errValid, 1);
        check(errCode == 2'd0, "R5", errCode, 0);
        @(posedge clk); #1;
        check(errValid == 1'b0, "R9", errValid, 0);
        // high byte alone over the limit
        sendByte(8'hE0, 0); sendByte(8'h01, 0); sendByte(8'h00, 0);
        @(negedge clk);
        check(errValid == 1'b1 && errCode == 2'd0, "R5", errCode, 0);
        @(posedge clk); #1;
        pay[0] = 8'h3C;
        sendBody(8'hE0, 16'd1, 8'h42, 0, acc);
        sendByte(acc, 0);
        settle(8);
        expectFrame(base, 8'hE0, 1, 8'h42, "R5");
        check(errTotal - ebase == 2, "R5", errTotal - ebase, 2);

        // R4: bad check byte
        base = beatTotal; ebase = errTotal;
        pay[0] = 8'hA5; pay[1] = 8'h0F; pay[2] = 8'hF0;
        sendBody(8'h60, 16'd3, 8'h09, 0, acc);
        sendByte(acc ^ 8'h01, 0);
        @(negedge clk);
        check(errValid == 1'b1, "R9", errValid, 1);
        check(errCode == 2'd1, "R4", errCode, 1);
        @(posedge clk); #1;
        settle(8);
        check(beatTotal == base, "R4", beatTotal - base, 0);
        check(errTotal - ebase == 1, "R4", errTotal - ebase, 1);

        // R6: silence one cycle past the limit
        ebase = errTotal;
        sendByte(8'h60, 0); sendByte(8'h00, 0);
        for (int k = 0; k <= GT; k++) begin
          @(negedge clk);
          check(errValid == 1'b0, "R6", errValid, 0);
        end
        @(negedge clk);
        check(errValid == 1'b1 && errCode == 2'd2, "R9", errCode, 2);
        @(posedge clk); #1;
        // hunting: long idle gives no event, then a late length byte is ignored
        settle(3 * GT);
        sendByte(8'h02, 2);
        check(errTotal - ebase == 1, "R6", errTotal - ebase, 1);
        base = beatTotal;
        sendBody(8'h60, 16'd0, 8'h55, 0, acc);
        sendByte(acc, 0);
        settle(6);
        expectFrame(base, 8'h60, 0, 8'h55, "R6");

        // R7 and R8: second frame behind a stalled delivery
        readyHold = 1'b0;
        settle(1);
        base = beatTotal; ebase = errTotal;
        pay[0] = 8'h81; pay[1] = 8'h92; pay[2] = 8'hA3;
        sendBody(8'hE0, 16'd3, 8'hC4, 0, acc);
        sendByte(acc, 0);
        for (int k = 0; k < 5; k++) begin
          @(negedge clk);
          check(outValid && outHead && outData == 8'hC4, "R8", outData, 8'hC4);
        end
        @(posedge clk); #1;
        pay[0] = 8'h01; pay[1] = 8'h02;
        sendBody(8'h60, 16'd2, 8'h33, 0, acc);
        sendByte(acc, 0);
        @(negedge clk);
        check(errValid == 1'b1 && errCode == 2'd3, "R7", errCode, 3);
        @(posedge clk); #1;
        pay[0] = 8'h81; pay[1] = 8'h92; pay[2] = 8'hA3;
        readyHold = 1'b1;
        settle(12);
        expectFrame(base, 8'hE0, 3, 8'hC4, "R7");
        check(errTotal - ebase == 1, "R7", errTotal - ebase, 1);
      end
      begin : watchdog
        repeat (150000) @(posedge clk);
        nChecks++;
        nErrors++;
        $display("FAIL watchdog: actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule